// File: doc/BRIEF.md
# Mode-Selected Even/Odd Sequence Counter

This block is a 3-bit synchronous counter with one mode input. Each rising clock edge moves the counter to a new state. In even-up mode it steps upward through the even values. In odd-down mode it steps downward through the odd values, and the cycle passes through zero.

All eight values have a fixed next state in both modes, so the counter is never left without a defined successor. A state that does not belong to the selected cycle leads back to zero within a bounded number of edges. The next-state function is a fixed table of sixteen mode/state pairs. It is written as three sum-of-products equations over the state bits.

The states are named `ST_ZERO` through `ST_SEVEN` after their value. The modes are `MODE_EVEN_UP` (mode input 0) and `MODE_ODD_DOWN` (mode input 1).

The transitions are:

| Mode | Cycle transitions | Recovery transitions |
|------|-------------------|----------------------|
| `MODE_EVEN_UP` | ZERO→TWO, TWO→FOUR, FOUR→SIX, SIX→ZERO | ONE→ZERO, THREE→FOUR, FIVE→SIX, SEVEN→ZERO |
| `MODE_ODD_DOWN` | ZERO→SEVEN, SEVEN→FIVE, FIVE→THREE, THREE→ONE, ONE→ZERO | TWO→FIVE, FOUR→SEVEN, SIX→FIVE |

Top module: `evod_counter`

## Requirements
- R1: The reset input is synchronous and active high. When it is high at a rising edge, the count becomes 0 at that edge, whatever the mode and the current count.
- R2: With mode input 0 held, the count starting from 0 runs 0, 2, 4, 6, 0 and repeats.
- R3: With mode input 1 held, the count starting from 0 runs 0, 7, 5, 3, 1, 0 and repeats.
- R4: With mode input 0, the odd values go 1 to 0, 3 to 4, 5 to 6 and 7 to 0.
- R5: With mode input 1, the nonzero even values go 2 to 5, 4 to 7 and 6 to 5.
- R6: A mode change is applied at the next rising edge. The new mode's transition is taken from the current count, and no intermediate step is inserted.
- R7: From any nonzero count, zero is reached when the mode is held. It takes at most 3 edges with mode input 0 and at most 5 edges with mode input 1.
- R8: Bit 0 of the count is 0 after every edge at which the mode input was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to count 0 |
| mode | input | 1 | 0 selects even-up, 1 selects odd-down |
| count | output | 3 | Current state; bit 2 is the most significant bit |

## Verification
Some behaviours are checked by assertions on every cycle:
- the forced zero after reset;
- the add-two step on even values in even-up mode;
- the subtract-two step on odd values in odd-down mode, and the wraps at 0 and 1;
- the cleared low bit after an even-up edge;
- the recovery bound, tracked by a counter of edges since the last zero.

Other behaviours only the bench scenarios can show:
- the recovery transitions in each mode;
- the effect of a mode switch in the middle of a cycle;
- reset taking priority over counting;
- the full sixteen-entry table, which the bench compares against its own copy.

// File: rtl/evod_pkg.sv
package evod_pkg;

    localparam int STATE_W     = 3;
    localparam int RECOVER_MAX = 5;
    localparam int RUN_W       = $clog2(RECOVER_MAX + 2) + 1;

    typedef enum logic [STATE_W-1:0] {
        ST_ZERO  = 3'd0,
        ST_ONE   = 3'd1,
        ST_TWO   = 3'd2,
        ST_THREE = 3'd3,
        ST_FOUR  = 3'd4,
        ST_FIVE  = 3'd5,
        ST_SIX   = 3'd6,
        ST_SEVEN = 3'd7
    } cnt_state_t;

    typedef enum logic {
        MODE_EVEN_UP  = 1'b0,
        MODE_ODD_DOWN = 1'b1
    } mode_t;

endpackage

// File: rtl/evod_next_state.sv
module evod_next_state
    import evod_pkg::*;
(
    input  mode_t      mode,
    input  cnt_state_t cur,
    output cnt_state_t nxt
);

    logic hi, mid, lo;
    logic n_hi, n_mid, n_lo;

    assign hi  = cur[2];
    assign mid = cur[1];
    assign lo  = cur[0];

    always_comb begin
        unique case (mode)
            MODE_EVEN_UP:  n_hi = hi ^ mid;
            MODE_ODD_DOWN: n_hi = (hi & mid) | ~lo;
            default:       n_hi = 1'b0;
        endcase
        n_mid = ~mid & (hi | ~lo);
        n_lo  = (mode == MODE_ODD_DOWN) & (hi | mid | ~lo);
        nxt   = cnt_state_t'({n_hi, n_mid, n_lo});
    end

endmodule

// File: rtl/evod_state_reg.sv
module evod_state_reg
    import evod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cnt_state_t d,
    output cnt_state_t q
);

    always_ff @(posedge clk) begin
        if (rst) q <= ST_ZERO;
        else     q <= d;
    end

endmodule

// File: rtl/evod_counter.sv
module evod_counter
    import evod_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mode,
    output logic [STATE_W-1:0] count
);

    cnt_state_t state_q;
    cnt_state_t state_d;
    mode_t      mode_sel;

    assign mode_sel = mode_t'(mode);

    evod_next_state u_next (
        .mode (mode_sel),
        .cur  (state_q),
        .nxt  (state_d)
    );

    evod_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (state_d),
        .q   (state_q)
    );

    always_comb begin
        count = state_q;
    end

    // Recovery monitor: edges taken from a nonzero count under an unchanged mode
    logic [RUN_W-1:0] run_q;
    logic             last_mode_q;

    always_ff @(posedge clk) begin
        last_mode_q <= mode;
        if (rst || state_q == ST_ZERO)  run_q <= '0;
        else if (mode != last_mode_q)   run_q <= RUN_W'(1);
        else if (run_q != '1)           run_q <= run_q + RUN_W'(1);
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> count == 3'd0);

    assert_even_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!mode && !count[0]) |=> count == $past(count) + 3'd2);

    assert_odd_step_R3: assert property (@(posedge clk) disable iff (rst)
        (mode && count[0] && count != 3'd1) |=> count == $past(count) - 3'd2);

    assert_odd_wrap_top_R3: assert property (@(posedge clk) disable iff (rst)
        (mode && count == 3'd0) |=> count == 3'd7);

    assert_odd_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (mode && count == 3'd1) |=> count == 3'd0);

    assert_lsb_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !mode |=> !count[0]);

    assert_recover_bound_R7: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(RECOVER_MAX));

endmodule

// File: tb/evod_counter_tb.sv
module evod_counter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0;
    logic [2:0] count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evod_counter u_dut (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .count (count)
    );

    function automatic logic [2:0] ref_next(input logic m, input logic [2:0] s);
        if (!m) begin
            case (s)
                3'd0: return 3'd2;  3'd1: return 3'd0;
                3'd2: return 3'd4;  3'd3: return 3'd4;
                3'd4: return 3'd6;  3'd5: return 3'd6;
                3'd6: return 3'd0;  default: return 3'd0;
            endcase
        end else begin
            case (s)
                3'd0: return 3'd7;  3'd1: return 3'd0;
                3'd2: return 3'd5;  3'd3: return 3'd1;
                3'd4: return 3'd7;  3'd5: return 3'd3;
                3'd6: return 3'd5;  default: return 3'd5;
            endcase
        end
    endfunction

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        rst = 1'b0;
    endtask

    task automatic goto_state(input logic [2:0] s);
        do_reset();
        if (!s[0]) begin
            mode = 1'b0;
            for (int i = 0; i < s / 2; i++) step();
        end else begin
            mode = 1'b1;
            for (int i = 0; i < (7 - s) / 2 + 1; i++) step();
        end
    endtask

    task automatic t_reset();
        mode = 1'b1;
        do_reset();
        chk("R1 reset state", count, 3'd0);
        step();
        step();
        chk("R1 counting before reset", count, 3'd5);
        rst = 1'b1;
        step();
        chk("R1 reset priority", count, 3'd0);
        rst = 1'b0;
    endtask

    task automatic t_even_seq();
        logic [2:0] exp;
        do_reset();
        mode = 1'b0;
        exp = 3'd0;
        for (int i = 0; i < 8; i++) begin
            step();
            exp = exp + 3'd2;
            chk("R2 even-up sequence", count, exp);
            chk("R8 low bit clear", {2'b00, count[0]}, 3'd0);
        end
    endtask

    task automatic t_odd_seq();
        logic [2:0] seq [5];
        seq = '{3'd7, 3'd5, 3'd3, 3'd1, 3'd0};
        do_reset();
        mode = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            chk("R3 odd-down sequence", count, seq[i % 5]);
        end
    endtask

    task automatic t_table();
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 8; s++) begin
                goto_state(3'(s));
                chk("R4/R5 setup", count, 3'(s));
                mode = 1'(m);
                step();
                if (m == 0 && s[0]) chk("R4 even-mode recovery", count, ref_next(1'b0, 3'(s)));
                else if (m == 1 && !s[0] && s != 0) chk("R5 odd-mode recovery", count, ref_next(1'b1, 3'(s)));
                else chk("R2/R3 table entry", count, ref_next(1'(m), 3'(s)));
            end
        end
    endtask

    task automatic t_mode_switch();
        do_reset();
        mode = 1'b0;
        step();
        step();
        chk("R6 pre-switch", count, 3'd4);
        mode = 1'b1;
        step();
        chk("R6 switch to odd-down from 4", count, 3'd7);
        mode = 1'b0;
        step();
        chk("R6 switch to even-up from 7", count, 3'd0);
        mode = 1'b1;
        step();
        step();
        chk("R6 odd-down run", count, 3'd5);
        mode = 1'b0;
        step();
        chk("R6 switch to even-up from 5", count, 3'd6);
    endtask

    task automatic t_recover();
        for (int m = 0; m < 2; m++) begin
            for (int s = 1; s < 8; s++) begin
                int edges;
                int bound;
                bound = (m == 0) ? 3 : 5;
                goto_state(3'(s));
                mode = 1'(m);
                edges = 0;
                while (count != 3'd0 && edges < 8) begin
                    step();
                    edges++;
                end
                checks++;
                if (edges > bound) begin
                    failures++;
                    $display("FAIL R7 start=%0d mode=%0d actual=%0d edges expected<=%0d",
                             s, m, edges, bound);
                end
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_even_seq();
        t_odd_seq();
        t_table();
        t_mode_switch();
        t_recover();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule